// File: doc/BRIEF.md
# Per-Rank DRAM Power-Down Controller

This block decides, for every rank of one DRAM channel, when the rank drops its clock enable to enter precharged power-down and when it wakes again. Each rank owns an idle counter that advances on every controller clock in which the request queues hold nothing for that rank. When the count reaches a programmable threshold, the mode allows power-down and all banks of the rank are closed, the rank is put into power-down. A new access for a sleeping rank wakes it at once. The rank then stays busy for a programmable exit latency so that the command scheduler holds back commands until the DRAM is ready.

The mode, threshold and exit-latency registers can be rewritten while the channel runs, unless a lock input is high. Switching the mode to "no power-down" wakes every sleeping rank through the normal exit wait. A one-cycle pulse per rank tells the page tracker that every row of that rank must be treated as closed after a wake.

Top module: `rank_pdn_ctrl`

## Requirements
- R1: After reset, `cke_low`, `rank_busy` and `page_clr` are all zero, and the mode register holds 0 (no power-down), so an idle rank does not enter power-down until the mode is written.
- R2: With mode 1 (precharged power-down) and threshold T ≥ 1, a rank whose `rank_pending` bit falls and stays low, with its banks closed, raises `cke_low` on the (T+1)-th rising edge after the fall. Any cycle with `rank_pending` high restarts the count.
- R3: Each rank enters and leaves power-down from its own inputs only. Activity, entry or wake of one rank does not change `cke_low` of any other rank.
- R4: A rank enters power-down only while its `rank_all_pre` bit is high. If the idle count is already met when the bit rises, `cke_low` rises on the next edge.
- R5: Mode 0 never asserts `cke_low`, and a threshold of 0 never asserts `cke_low` in any mode.
- R6: `rank_busy` is high whenever `cke_low` is high. An access (`rank_pending` high) to a sleeping rank clears `cke_low` on the next edge. `rank_busy` then remains high for exactly the programmed exit latency (≥ 1) cycles and clears.
- R7: `page_clr` pulses high for exactly one cycle, the first cycle after `cke_low` falls, and at no other time.
- R8: Writing mode 0 while a rank sleeps wakes it. `cke_low` falls on the second edge after the write edge, followed by the same exit-latency busy window as R6.
- R9: A write (`cfg_wr_en` high) with `cfg_lock` low loads mode, threshold and exit latency together on the next edge. A write while `cfg_lock` is high changes none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Load the three configuration registers |
| cfg_lock | input | 1 | Reject configuration writes while high |
| cfg_wr_mode | input | 1 | Mode to write: 0 no power-down, 1 precharged power-down |
| cfg_wr_thresh | input | IDLE_W | Idle cycles before entry; 0 disables entry |
| cfg_wr_txp | input | TXP_W | Exit latency in cycles |
| rank_pending | input | NUM_RANKS | Per rank: a request is waiting in the queues |
| rank_all_pre | input | NUM_RANKS | Per rank: every bank is precharged |
| cke_low | output | NUM_RANKS | Per rank: hold clock enable low (in power-down) |
| rank_busy | output | NUM_RANKS | Per rank: commands blocked (asleep or waking) |
| page_clr | output | NUM_RANKS | Per rank: one-cycle pulse to empty open-page tracking |

## Verification
Entry timing is measured against a table of threshold and exit-latency pairs, one per rank. A short and a long threshold separate an off-by-one in the idle count from a counter that never saturates. An idle stretch broken by one pending cycle shows that the count restarts rather than pausing. Holding one rank's banks open, zeroing the threshold, and writing mode 0 to a sleeping rank tell apart the three ways entry is suppressed or undone, and two ranks asleep together with only one woken confirm the per-rank split. A locked write followed by an entry measurement shows that the old threshold still governs.

// File: rtl/rank_pdn_pkg.sv
package rank_pdn_pkg;
   typedef enum logic [1:0] {
      ST_UP   = 2'd0,
      ST_DOWN = 2'd1,
      ST_WAKE = 2'd2
   } pdn_state_e;

   typedef enum logic {
      MODE_OFF = 1'b0,
      MODE_PPD = 1'b1
   } pdn_mode_e;
endpackage

// File: rtl/rank_pdn_cfg.sv
module rank_pdn_cfg
   import rank_pdn_pkg::*;
#(
   parameter int IDLE_W     = 8,
   parameter int TXP_W      = 4,
   parameter int DEF_THRESH = 16,
   parameter int DEF_TXP    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              lock,
   input  logic              wr_mode,
   input  logic [IDLE_W-1:0] wr_thresh,
   input  logic [TXP_W-1:0]  wr_txp,
   output pdn_mode_e         mode_q,
   output logic [IDLE_W-1:0] thresh_q,
   output logic [TXP_W-1:0]  txp_q
);
   localparam logic [IDLE_W-1:0] RST_THRESH = IDLE_W'(DEF_THRESH);
   localparam logic [TXP_W-1:0]  RST_TXP    = TXP_W'(DEF_TXP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_OFF;
         thresh_q <= RST_THRESH;
         txp_q    <= RST_TXP;
      end else if (wr_en && !lock) begin
         mode_q   <= pdn_mode_e'(wr_mode);
         thresh_q <= wr_thresh;
         txp_q    <= wr_txp;
      end
   end
endmodule

// File: rtl/rank_pdn_fsm.sv
module rank_pdn_fsm
   import rank_pdn_pkg::*;
#(
   parameter int IDLE_W = 8,
   parameter int TXP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pending,
   input  logic              all_pre,
   input  logic              entry_en,
   input  logic              force_exit,
   input  logic [IDLE_W-1:0] thresh,
   input  logic [TXP_W-1:0]  txp,
   output logic              cke_low,
   output logic              busy,
   output logic              page_clr
);
   localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

   pdn_state_e        st_q;
   logic [IDLE_W-1:0] idle_q;
   logic [TXP_W-1:0]  wake_q;
   logic              clr_q;
   logic              entry_ok;

   assign entry_ok = entry_en && !pending && all_pre && (idle_q >= thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_UP;
         idle_q <= '0;
         wake_q <= '0;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         unique case (st_q)
            ST_UP: begin
               if (pending)
                  idle_q <= '0;
               else if (idle_q != IDLE_MAX)
                  idle_q <= idle_q + 1'b1;
               if (entry_ok) begin
                  st_q   <= ST_DOWN;
                  idle_q <= '0;
               end
            end
            ST_DOWN: begin
               if (pending || force_exit) begin
                  clr_q <= 1'b1;
                  if (txp == '0) begin
                     st_q <= ST_UP;
                  end else begin
                     st_q   <= ST_WAKE;
                     wake_q <= txp;
                  end
               end
            end
            ST_WAKE: begin
               if (wake_q <= 1)
                  st_q <= ST_UP;
               else
                  wake_q <= wake_q - 1'b1;
            end
            default: st_q <= ST_UP;
         endcase
      end
   end

   assign cke_low  = (st_q == ST_DOWN);
   assign busy     = (st_q != ST_UP);
   assign page_clr = clr_q;
endmodule

// File: rtl/rank_pdn_ctrl.sv
module rank_pdn_ctrl
   import rank_pdn_pkg::*;
#(
   parameter int NUM_RANKS  = 4,
   parameter int IDLE_W     = 8,
   parameter int TXP_W      = 4,
   parameter int DEF_THRESH = 16,
   parameter int DEF_TXP    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_en,
   input  logic                 cfg_lock,
   input  logic                 cfg_wr_mode,
   input  logic [IDLE_W-1:0]    cfg_wr_thresh,
   input  logic [TXP_W-1:0]     cfg_wr_txp,
   input  logic [NUM_RANKS-1:0] rank_pending,
   input  logic [NUM_RANKS-1:0] rank_all_pre,
   output logic [NUM_RANKS-1:0] cke_low,
   output logic [NUM_RANKS-1:0] rank_busy,
   output logic [NUM_RANKS-1:0] page_clr
);
   if (NUM_RANKS < 1) begin : g_bad_ranks
      $error("rank_pdn_ctrl: NUM_RANKS must be at least 1");
   end
   if (IDLE_W < 2 || IDLE_W > 32) begin : g_bad_idle
      $error("rank_pdn_ctrl: IDLE_W must be 2..32");
   end
   if (TXP_W < 1 || TXP_W > 16) begin : g_bad_txp
      $error("rank_pdn_ctrl: TXP_W must be 1..16");
   end
   if (DEF_THRESH < 0 || DEF_THRESH >= (64'd1 << IDLE_W)) begin : g_bad_dthr
      $error("rank_pdn_ctrl: DEF_THRESH does not fit IDLE_W");
   end
   if (DEF_TXP < 0 || DEF_TXP >= (64'd1 << TXP_W)) begin : g_bad_dtxp
      $error("rank_pdn_ctrl: DEF_TXP does not fit TXP_W");
   end

   pdn_mode_e         mode_q;
   logic [IDLE_W-1:0] thresh_q;
   logic [TXP_W-1:0]  txp_q;
   logic              entry_en;
   logic              force_exit;

   rank_pdn_cfg #(
      .IDLE_W    (IDLE_W),
      .TXP_W     (TXP_W),
      .DEF_THRESH(DEF_THRESH),
      .DEF_TXP   (DEF_TXP)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .lock     (cfg_lock),
      .wr_mode  (cfg_wr_mode),
      .wr_thresh(cfg_wr_thresh),
      .wr_txp   (cfg_wr_txp),
      .mode_q   (mode_q),
      .thresh_q (thresh_q),
      .txp_q    (txp_q)
   );

   assign entry_en   = (mode_q == MODE_PPD) && (thresh_q != '0);
   assign force_exit = (mode_q == MODE_OFF);

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      rank_pdn_fsm #(
         .IDLE_W(IDLE_W),
         .TXP_W (TXP_W)
      ) u_fsm (
         .clk       (clk),
         .rst_n     (rst_n),
         .pending   (rank_pending[r]),
         .all_pre   (rank_all_pre[r]),
         .entry_en  (entry_en),
         .force_exit(force_exit),
         .thresh    (thresh_q),
         .txp       (txp_q),
         .cke_low   (cke_low[r]),
         .busy      (rank_busy[r]),
         .page_clr  (page_clr[r])
      );
   end
endmodule

// File: rtl/rank_pdn_chk.sv
module rank_pdn_chk #(
   parameter int NUM_RANKS = 4,
   parameter int IDLE_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_lock,
   input logic                 mode_bit,
   input logic [IDLE_W-1:0]    thresh_q,
   input logic [NUM_RANKS-1:0] rank_pending,
   input logic [NUM_RANKS-1:0] rank_all_pre,
   input logic [NUM_RANKS-1:0] cke_low,
   input logic [NUM_RANKS-1:0] rank_busy,
   input logic [NUM_RANKS-1:0] page_clr
);
   // R9
   cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_lock |=> ($stable(thresh_q) && $stable(mode_bit)));

   for (genvar i = 0; i < NUM_RANKS; i++) begin : g_chk
      // R4
      entry_closed_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cke_low[i]) |-> $past(rank_all_pre[i] && !rank_pending[i]));
      // R5
      entry_mode_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cke_low[i]) |-> $past(mode_bit && (thresh_q != '0)));
      // R6
      wake_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cke_low[i] && rank_pending[i]) |=> !cke_low[i]);
      // R6
      busy_while_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cke_low[i] |-> rank_busy[i]);
      // R7
      flush_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(cke_low[i]) |-> page_clr[i]);
      // R7
      flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         page_clr[i] |=> !page_clr[i]);
      // R8
      mode_off_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cke_low[i] && !mode_bit) |=> !cke_low[i]);
   end
endmodule

bind rank_pdn_ctrl rank_pdn_chk #(
   .NUM_RANKS(NUM_RANKS),
   .IDLE_W   (IDLE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_lock    (cfg_lock),
   .mode_bit    (mode_q),
   .thresh_q    (thresh_q),
   .rank_pending(rank_pending),
   .rank_all_pre(rank_all_pre),
   .cke_low     (cke_low),
   .rank_busy   (rank_busy),
   .page_clr    (page_clr)
);

// File: tb/rank_pdn_ctrl_tb.sv
module rank_pdn_ctrl_tb;
   localparam int NR = 4;
   localparam int IW = 8;
   localparam int TW = 4;

   // vector table: rank, threshold, exit latency
   localparam int NV = 4;
   localparam int V_RANK [NV] = '{0, 1, 2, 3};
   localparam int V_THR  [NV] = '{3, 1, 6, 2};
   localparam int V_TXP  [NV] = '{2, 1, 4, 3};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic          cfg_lock = 1'b0;
   logic          cfg_wr_mode = 1'b0;
   logic [IW-1:0] cfg_wr_thresh = '0;
   logic [TW-1:0] cfg_wr_txp = '0;
   logic [NR-1:0] rank_pending = '1;
   logic [NR-1:0] rank_all_pre = '1;
   logic [NR-1:0] cke_low;
   logic [NR-1:0] rank_busy;
   logic [NR-1:0] page_clr;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   rank_pdn_ctrl #(.NUM_RANKS(NR), .IDLE_W(IW), .TXP_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_lock(cfg_lock), .cfg_wr_mode(cfg_wr_mode),
      .cfg_wr_thresh(cfg_wr_thresh), .cfg_wr_txp(cfg_wr_txp),
      .rank_pending(rank_pending), .rank_all_pre(rank_all_pre),
      .cke_low(cke_low), .rank_busy(rank_busy), .page_clr(page_clr)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input bit mode, input int thr, input int txp);
      cfg_wr_mode   = mode;
      cfg_wr_thresh = IW'(thr);
      cfg_wr_txp    = TW'(txp);
      cfg_wr_en     = 1'b1;
      @(negedge clk);
      cfg_wr_en     = 1'b0;
   endtask

   // drop pending of rank r and count negedges until cke_low rises (0 = never in limit)
   task automatic enter_count(input int r, input int limit, output int n);
      n = 0;
      rank_pending[r] = 1'b0;
      for (int k = 1; k <= limit; k++) begin
         @(negedge clk);
         if (cke_low[r]) begin
            n = k;
            break;
         end
      end
   endtask

   // called at the negedge where cke_low just fell; counts busy cycles and flush pulses
   task automatic count_wake(input int r, output int nb, output int np);
      nb = 0;
      np = 0;
      for (int k = 0; k < 40; k++) begin
         if (page_clr[r]) np++;
         if (rank_busy[r]) nb++;
         else break;
         @(negedge clk);
      end
   endtask

   initial begin
      int n, nb, np;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(cke_low == '0, "R1 cke_low after reset", int'(cke_low), 0);
      chk(rank_busy == '0, "R1 rank_busy after reset", int'(rank_busy), 0);
      chk(page_clr == '0, "R1 page_clr after reset", int'(page_clr), 0);
      // R1 / R5: default mode is no power-down
      enter_count(0, 40, n);
      chk(n == 0, "R1 no entry in reset mode", n, 0);
      rank_pending[0] = 1'b1;
      @(negedge clk);

      // R2 R6 R7 R9 R3: table of vectors
      for (int v = 0; v < NV; v++) begin
         int r;
         r = V_RANK[v];
         cfg_write(1'b1, V_THR[v], V_TXP[v]);
         enter_count(r, 64, n);
         chk(n == V_THR[v] + 1, "R2 entry cycle count", n, V_THR[v] + 1);
         chk((cke_low & ~(NR'(1) << r)) == '0, "R3 other ranks stay up",
             int'(cke_low), int'(NR'(1) << r));
         chk(rank_busy[r] == 1'b1, "R6 busy while down", rank_busy[r], 1);
         rank_pending[r] = 1'b1;
         @(negedge clk);
         chk(cke_low[r] == 1'b0, "R6 wake on access next edge", cke_low[r], 0);
         chk(page_clr[r] == 1'b1, "R7 flush pulse on wake", page_clr[r], 1);
         count_wake(r, nb, np);
         chk(nb == V_TXP[v], "R6 exit latency cycles", nb, V_TXP[v]);
         chk(np == 1, "R7 single flush pulse", np, 1);
      end

      // R2: pending restarts count
      cfg_write(1'b1, 3, 1);
      rank_pending[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rank_pending[0] = 1'b1;
      @(negedge clk);
      chk(cke_low[0] == 1'b0, "R2 no entry before threshold", cke_low[0], 0);
      enter_count(0, 64, n);
      chk(n == 4, "R2 count restarts after access", n, 4);
      rank_pending[0] = 1'b1;
      repeat (4) @(negedge clk);

      // R4: open bank blocks entry
      rank_all_pre[1] = 1'b0;
      enter_count(1, 12, n);
      chk(n == 0, "R4 no entry with open bank", n, 0);
      rank_all_pre[1] = 1'b1;
      @(negedge clk);
      chk(cke_low[1] == 1'b1, "R4 entry one edge after banks close", cke_low[1], 1);
      rank_pending[1] = 1'b1;
      repeat (4) @(negedge clk);

      // R3: two ranks asleep, wake only one
      cfg_write(1'b1, 2, 2);
      rank_pending[0] = 1'b0;
      rank_pending[1] = 1'b0;
      repeat (3) @(negedge clk);
      chk(cke_low[1:0] == 2'b11, "R3 both ranks asleep", int'(cke_low[1:0]), 3);
      rank_pending[0] = 1'b1;
      repeat (5) @(negedge clk);
      chk(cke_low[1:0] == 2'b10, "R3 other rank stays asleep", int'(cke_low[1:0]), 2);
      rank_pending[1] = 1'b1;
      repeat (4) @(negedge clk);

      // R5: threshold zero disables entry
      cfg_write(1'b1, 0, 2);
      enter_count(2, 30, n);
      chk(n == 0, "R5 zero threshold never enters", n, 0);
      rank_pending[2] = 1'b1;
      @(negedge clk);

      // R8: switching to mode 0 wakes a sleeping rank
      cfg_write(1'b1, 2, 3);
      enter_count(2, 64, n);
      chk(n == 3, "R8 setup entry", n, 3);
      cfg_write(1'b0, 2, 3);
      chk(cke_low[2] == 1'b1, "R8 still asleep one edge after write", cke_low[2], 1);
      @(negedge clk);
      chk(cke_low[2] == 1'b0, "R8 woken second edge after write", cke_low[2], 0);
      count_wake(2, nb, np);
      chk(nb == 3, "R8 exit latency after mode switch", nb, 3);
      chk(np == 1, "R7 flush on forced wake", np, 1);
      repeat (10) @(negedge clk);
      chk(cke_low[2] == 1'b0, "R5 mode 0 stays awake while idle", cke_low[2], 0);
      rank_pending[2] = 1'b1;
      @(negedge clk);

      // R9: locked write rejected
      cfg_write(1'b1, 2, 1);
      cfg_lock = 1'b1;
      cfg_write(1'b1, 9, 5);
      enter_count(3, 64, n);
      chk(n == 3, "R9 locked write ignored", n, 3);
      rank_pending[3] = 1'b1;
      @(negedge clk);
      count_wake(3, nb, np);
      chk(nb == 1, "R9 locked exit latency unchanged", nb, 1);
      cfg_lock = 1'b0;
      cfg_write(1'b1, 5, 1);
      enter_count(3, 64, n);
      chk(n == 6, "R9 unlocked write accepted", n, 6);
      rank_pending[3] = 1'b1;
      repeat (4) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule